// File: doc/BRIEF.md
# Voltage ID code translator

This block sits between a processor's voltage-request pins and a downstream core-voltage regulator. It accepts voltage requests either as 7-bit serial codes with a power-save flag, delivered one rail at a time, or as a 6-bit parallel code. It produces an 8-bit serial byte for each of three rails (north-bridge, core 0, core 1) and a 5-bit parallel code for a parallel-only regulator. Two mode inputs choose the direction: whether the processor speaks serial or parallel, and whether the regulator is serial or parallel.

Each rail's value is picked by priority. A fixed-mode strap comes first, then a pre-power-good boot strap, then a manual override, then the live processor request. A signed per-rail trim is then applied, and the result is clamped to the legal range. In serial-output mode the north-bridge rail is switched off when the processor is parallel, and one rail can mirror the other. The raw parallel input is also returned in a formatted readback byte. Every output is registered and changes one clock after the inputs that cause it.

Top module: `vid_xlate`

## Requirements
- R1: While `rst` is high, each `ser_out` byte is 0xBC, `par_out` is 30 and `pvi_rb` is 0.
- R2: With `vfix_en` high, whatever the level of `pwrok`, a rail with zero trim carries code 0x0C, 0x1C, 0x2C or 0x3C for straps {strap_clk,strap_dat} = 00, 01, 10, 11, and its bit 7 is 1.
- R3: With `vfix_en` low and `pwrok` low, a rail with zero trim carries 0x24, 0x2C, 0x34 or 0x3C for straps 00, 01, 10, 11. The rail store is loaded with that value.
- R4: After `pwrok`, a `cmd_valid` cycle stores `cmd_byte` into the rail named by `cmd_rail` (0 = north-bridge, 1 = core 0, 2 = core 1). Bit 6..0 is the code (0 = 1.55 V, each step 12.5 mV lower). Bit 7 is the active-low power-save flag, and it reaches bit 7 of that rail's output unchanged. Commands are ignored while `pwrok` is low.
- R5: Output code = base code minus the two's-complement `rail_offset` byte, so a positive trim raises the voltage. The result is clamped to 0..0x7B.
- R6: With a serial processor and a parallel regulator, the core-0 code is clamped to 0..0x3D.
- R7: `par_out` is the core-0 code shifted right by one, saturated at 31. A parallel input p maps to code 2p for p < 32 and to p+31 otherwise.
- R8: In serial-output mode a base code of 0x7C..0x7F passes through with no trim. In parallel-output mode it is trimmed and clamped like any other code.
- R9: With a parallel processor, bit 7 of every rail is 1. In serial-output mode the north-bridge byte is then 0xFF, the off code.
- R10: In serial-output mode, `mirror_sel` = 01 copies the north-bridge byte onto core 0, and 10 copies core 0 onto north-bridge. The off code of R9 overrides the copy. In parallel-output mode `mirror_sel` has no effect.
- R11: `pvi_rb` = {0, pvi_in, 0}, so 111111 reads 0x7E.
- R12: After `pwrok` with `vfix_en` low, `man_en[i]` replaces rail i's base with `man_code[i]`. The manual value is ignored while `pwrok` is low.
- R13: Outputs change on the clock after their inputs. A stored command shows on the second clock after `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrok | input | 1 | Processor power-good |
| vfix_en | input | 1 | Fixed-voltage strap enable |
| strap_clk | input | 1 | Strap level on serial clock line |
| strap_dat | input | 1 | Strap level on serial data line |
| core_serial | input | 1 | 1: processor issues serial codes |
| out_serial | input | 1 | 1: regulator takes serial bytes |
| cmd_valid | input | 1 | Serial command strobe |
| cmd_rail | input | 2 | Target rail of the command |
| cmd_byte | input | 8 | Power-save flag and 7-bit code |
| pvi_in | input | 6 | Parallel processor code |
| man_en | input | 3 | Per-rail manual enable |
| man_code | input | 21 | Per-rail manual codes, 7 bits each |
| rail_offset | input | 24 | Per-rail signed trim, 8 bits each |
| mirror_sel | input | 2 | Rail mirroring select |
| ser_out | output | 24 | Serial bytes: [7:0] north-bridge, [15:8] core 0, [23:16] core 1 |
| par_out | output | 5 | Parallel regulator code |
| pvi_rb | output | 8 | Formatted parallel readback |

## Verification
The hardest corners to reach are the ones that need a particular stored command under a particular mode pair. Examples are an off code held in a rail while trim is applied, or a core-0 code past 0x3D while the regulator is parallel. The stimulus first raises `pwrok` so the store accepts commands. It loads each rail through `cmd_valid`, then flips the mode inputs and the trims without touching the store. The same stored value is then seen through every mode, clamp and mirror path in turn.

// File: rtl/vidx_pkg.sv
package vidx_pkg;

    localparam int NRAIL    = 3;
    localparam int CODE_W   = 7;
    localparam int OFF_W    = 8;
    localparam int PVI_W    = 6;
    localparam int POUT_W   = 5;
    localparam int RSEL_W   = $clog2(NRAIL);
    localparam int SUM_W    = OFF_W + 1;
    localparam int BYTE_W   = CODE_W + 1;

    localparam logic [CODE_W-1:0] OFF_FIRST = 7'h7C;
    localparam logic [CODE_W-1:0] RST_CODE  = 7'h3C;
    localparam logic [POUT_W-1:0] POUT_MAX  = '1;

    typedef enum logic [RSEL_W-1:0] {
        RAIL_NB   = 2'd0,
        RAIL_VDD0 = 2'd1,
        RAIL_VDD1 = 2'd2
    } rail_e;

    typedef struct packed {
        logic              psi_n;
        logic [CODE_W-1:0] code;
    } rail_cmd_t;

    localparam rail_cmd_t RST_CMD = '{psi_n: 1'b1, code: RST_CODE};

    function automatic logic [CODE_W-1:0] fixed_code(input logic [1:0] s);
        return {1'b0, s, 4'hC};
    endfunction

    function automatic logic [CODE_W-1:0] boot_code(input logic [1:0] s);
        return {2'b01, s, 3'b100};
    endfunction

    function automatic logic [CODE_W-1:0] pvi_to_code(input logic [PVI_W-1:0] p);
        if (p[PVI_W-1])
            return CODE_W'(p) + CODE_W'(31);
        return {p[PVI_W-2:0], 1'b0};
    endfunction

    function automatic logic [POUT_W-1:0] code_to_pvi(input logic [CODE_W-1:0] c);
        if (c[CODE_W-1])
            return POUT_MAX;
        return c[POUT_W:1];
    endfunction

    function automatic logic [CODE_W-1:0] trim_clamp(input logic [CODE_W-1:0] base,
                                                     input logic [OFF_W-1:0]  off,
                                                     input logic [CODE_W-1:0] lim);
        logic signed [SUM_W-1:0] b;
        logic signed [SUM_W-1:0] o;
        logic signed [SUM_W-1:0] s;
        b = $signed(SUM_W'(base));
        o = SUM_W'($signed(off));
        s = b - o;
        if (s < 0)
            return '0;
        if (s > $signed(SUM_W'(lim)))
            return lim;
        return s[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/vidx_rail_store.sv
module vidx_rail_store
    import vidx_pkg::*;
#(
    parameter int RAIL_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwrok,
    input  logic [CODE_W-1:0] boot_val,
    input  logic              cmd_valid,
    input  logic [RSEL_W-1:0] cmd_rail,
    input  rail_cmd_t         cmd,
    output rail_cmd_t         held
);

    localparam logic [RSEL_W-1:0] MY_SEL = RSEL_W'(RAIL_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= RST_CMD;
        end else if (!pwrok) begin
            held.psi_n <= 1'b1;
            held.code  <= boot_val;
        end else if (cmd_valid && cmd_rail == MY_SEL) begin
            held <= cmd;
        end
    end

endmodule

// File: rtl/vidx_rail_calc.sv
module vidx_rail_calc
    import vidx_pkg::*;
#(
    parameter logic [CODE_W-1:0] WIDE_MAX   = 7'h7B,
    parameter logic [CODE_W-1:0] NARROW_MAX = 7'h3D
) (
    input  logic              fix_mode,
    input  logic              pwrok,
    input  logic [CODE_W-1:0] fix_val,
    input  logic [CODE_W-1:0] boot_val,
    input  logic              man_en,
    input  logic [CODE_W-1:0] man_val,
    input  logic              src_serial,
    input  rail_cmd_t         held,
    input  logic [CODE_W-1:0] pvi_val,
    input  logic [OFF_W-1:0]  trim,
    input  logic              out_serial,
    input  logic              narrow,
    output rail_cmd_t         result
);

    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] lim;
    logic              is_off;

    always_comb begin
        if (fix_mode)
            base = fix_val;
        else if (!pwrok)
            base = boot_val;
        else if (man_en)
            base = man_val;
        else if (src_serial)
            base = held.code;
        else
            base = pvi_val;
    end

    assign lim    = narrow ? NARROW_MAX : WIDE_MAX;
    assign is_off = out_serial && (base >= OFF_FIRST);

    always_comb begin
        result.code  = is_off ? base : trim_clamp(base, trim, lim);
        result.psi_n = (src_serial && pwrok && !fix_mode) ? held.psi_n : 1'b1;
    end

endmodule

// File: rtl/vid_xlate.sv
module vid_xlate
    import vidx_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_MAX     = 7'h7B,
    parameter logic [CODE_W-1:0] S2P_VDD0_MAX = 7'h3D
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pwrok,
    input  logic                           vfix_en,
    input  logic                           strap_clk,
    input  logic                           strap_dat,
    input  logic                           core_serial,
    input  logic                           out_serial,
    input  logic                           cmd_valid,
    input  logic [RSEL_W-1:0]              cmd_rail,
    input  logic [BYTE_W-1:0]              cmd_byte,
    input  logic [PVI_W-1:0]               pvi_in,
    input  logic [NRAIL-1:0]               man_en,
    input  logic [NRAIL-1:0][CODE_W-1:0]   man_code,
    input  logic [NRAIL-1:0][OFF_W-1:0]    rail_offset,
    input  logic [1:0]                     mirror_sel,
    output logic [NRAIL-1:0][BYTE_W-1:0]   ser_out,
    output logic [POUT_W-1:0]              par_out,
    output logic [BYTE_W-1:0]              pvi_rb
);

    localparam int NB = int'(RAIL_NB);
    localparam int V0 = int'(RAIL_VDD0);

    logic [1:0]        strap;
    logic [CODE_W-1:0] fix_val;
    logic [CODE_W-1:0] boot_val;
    logic [CODE_W-1:0] pvi_val;
    rail_cmd_t         cmd;
    rail_cmd_t         held [NRAIL];
    rail_cmd_t         calc [NRAIL];
    rail_cmd_t         mixed [NRAIL];

    assign strap    = {strap_clk, strap_dat};
    assign fix_val  = fixed_code(strap);
    assign boot_val = boot_code(strap);
    assign pvi_val  = pvi_to_code(pvi_in);
    assign cmd      = rail_cmd_t'(cmd_byte);

    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        localparam bit IS_VDD0 = (g == V0);
        logic narrow;
        assign narrow = IS_VDD0 && core_serial && !out_serial;

        vidx_rail_store #(.RAIL_ID(g)) u_store (
            .clk       (clk),
            .rst       (rst),
            .pwrok     (pwrok),
            .boot_val  (boot_val),
            .cmd_valid (cmd_valid),
            .cmd_rail  (cmd_rail),
            .cmd       (cmd),
            .held      (held[g])
        );

        vidx_rail_calc #(
            .WIDE_MAX   (CODE_MAX),
            .NARROW_MAX (S2P_VDD0_MAX)
        ) u_calc (
            .fix_mode   (vfix_en),
            .pwrok      (pwrok),
            .fix_val    (fix_val),
            .boot_val   (boot_val),
            .man_en     (man_en[g]),
            .man_val    (man_code[g]),
            .src_serial (core_serial),
            .held       (held[g]),
            .pvi_val    (pvi_val),
            .trim       (rail_offset[g]),
            .out_serial (out_serial),
            .narrow     (narrow),
            .result     (calc[g])
        );
    end

    always_comb begin
        for (int i = 0; i < NRAIL; i++)
            mixed[i] = calc[i];
        if (out_serial) begin
            unique case (mirror_sel)
                2'b01:   mixed[V0] = calc[NB];
                2'b10:   mixed[NB] = calc[V0];
                default: ;
            endcase
            if (!core_serial)
                mixed[NB] = '{psi_n: 1'b1, code: '1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NRAIL; i++)
                ser_out[i] <= RST_CMD;
            par_out <= code_to_pvi(RST_CODE);
            pvi_rb  <= '0;
        end else begin
            for (int i = 0; i < NRAIL; i++)
                ser_out[i] <= mixed[i];
            par_out <= code_to_pvi(mixed[V0].code);
            pvi_rb  <= {1'b0, pvi_in, 1'b0};
        end
    end

endmodule

// File: rtl/vidx_checks.sv
module vidx_checks
    import vidx_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         pwrok,
    input logic                         vfix_en,
    input logic                         strap_clk,
    input logic                         strap_dat,
    input logic                         core_serial,
    input logic                         out_serial,
    input logic [PVI_W-1:0]             pvi_in,
    input logic [NRAIL-1:0][OFF_W-1:0]  rail_offset,
    input logic [1:0]                   mirror_sel,
    input logic [NRAIL-1:0][BYTE_W-1:0] ser_out,
    input logic [POUT_W-1:0]            par_out,
    input logic [BYTE_W-1:0]            pvi_rb
);

    p_fixed_tab_r2: assert property (@(posedge clk) disable iff (rst)
        (vfix_en && rail_offset[2] == '0) |=>
            ser_out[2] == {2'b10, $past(strap_clk), $past(strap_dat), 4'hC});

    p_boot_tab_r3: assert property (@(posedge clk) disable iff (rst)
        (!vfix_en && !pwrok && rail_offset[2] == '0) |=>
            ser_out[2] == {3'b101, $past(strap_clk), $past(strap_dat), 3'b100});

    p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
        !out_serial |=> (ser_out[0][6:0] <= 7'h7B && ser_out[1][6:0] <= 7'h7B
                         && ser_out[2][6:0] <= 7'h7B));

    p_vdd0_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        (core_serial && !out_serial) |=> (ser_out[1][6:0] <= 7'h3D && par_out <= 5'd30));

    p_psi_parallel_r9: assert property (@(posedge clk) disable iff (rst)
        !core_serial |=> (ser_out[0][7] && ser_out[1][7] && ser_out[2][7]));

    p_nb_off_r9: assert property (@(posedge clk) disable iff (rst)
        (out_serial && !core_serial) |=> ser_out[0] == 8'hFF);

    p_mirror_r10: assert property (@(posedge clk) disable iff (rst)
        (out_serial && core_serial && mirror_sel == 2'b01) |=> ser_out[1] == ser_out[0]);

    p_readback_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pvi_rb == {1'b0, $past(pvi_in), 1'b0});

endmodule

bind vid_xlate vidx_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwrok       (pwrok),
    .vfix_en     (vfix_en),
    .strap_clk   (strap_clk),
    .strap_dat   (strap_dat),
    .core_serial (core_serial),
    .out_serial  (out_serial),
    .pvi_in      (pvi_in),
    .rail_offset (rail_offset),
    .mirror_sel  (mirror_sel),
    .ser_out     (ser_out),
    .par_out     (par_out),
    .pvi_rb      (pvi_rb)
);

// File: tb/vid_xlate_tb_top.sv
module vid_xlate_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1;
    logic             pwrok = 1'b0, vfix_en = 1'b0, strap_clk = 1'b0, strap_dat = 1'b0;
    logic             core_serial = 1'b1, out_serial = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_rail = '0;
    logic [7:0]       cmd_byte = '0;
    logic [5:0]       pvi_in = '0;
    logic [2:0]       man_en = '0;
    logic [2:0][6:0]  man_code = '0;
    logic [2:0][7:0]  off = '0;
    logic [1:0]       mirror_sel = '0;
    logic [2:0][7:0]  ser_out;
    logic [4:0]       par_out;
    logic [7:0]       pvi_rb;

    vid_xlate dut_i (
        .clk(clk), .rst(rst), .pwrok(pwrok), .vfix_en(vfix_en),
        .strap_clk(strap_clk), .strap_dat(strap_dat),
        .core_serial(core_serial), .out_serial(out_serial),
        .cmd_valid(cmd_valid), .cmd_rail(cmd_rail), .cmd_byte(cmd_byte),
        .pvi_in(pvi_in), .man_en(man_en), .man_code(man_code),
        .rail_offset(off), .mirror_sel(mirror_sel),
        .ser_out(ser_out), .par_out(par_out), .pvi_rb(pvi_rb)
    );

    typedef struct {
        logic [2:0][7:0] ser;
        logic [4:0]      par;
        logic [7:0]      rb;
        string           tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    logic [6:0] m_code [3] = '{7'h3C, 7'h3C, 7'h3C};
    logic       m_psi  [3] = '{1'b1, 1'b1, 1'b1};

    function automatic logic [7:0] model_rail(int i);
        int base, v, lim;
        logic [1:0] s;
        logic psi;
        s = {strap_clk, strap_dat};
        if (vfix_en)          base = 12 + 16 * int'(s);
        else if (!pwrok)      base = 36 + 8 * int'(s);
        else if (man_en[i])   base = int'(man_code[i]);
        else if (core_serial) base = int'(m_code[i]);
        else                  base = (pvi_in < 32) ? 2 * int'(pvi_in) : int'(pvi_in) + 31;
        if (out_serial && base >= 124) begin
            v = base;
        end else begin
            lim = (i == 1 && core_serial && !out_serial) ? 61 : 123;
            v = base - int'($signed(off[i]));
            if (v < 0) v = 0;
            if (v > lim) v = lim;
        end
        psi = (core_serial && pwrok && !vfix_en) ? m_psi[i] : 1'b1;
        return {psi, 7'(v)};
    endfunction

    task automatic step(string tag);
        exp_t e;
        logic [7:0] r0, r1, r2;
        r0 = model_rail(0);
        r1 = model_rail(1);
        r2 = model_rail(2);
        if (out_serial) begin
            if (mirror_sel == 2'b01) r1 = r0;
            else if (mirror_sel == 2'b10) r0 = r1;
            if (!core_serial) r0 = 8'hFF;
        end
        e.ser = {r2, r1, r0};
        e.par = r1[6] ? 5'd31 : r1[5:1];
        e.rb  = {1'b0, pvi_in, 1'b0};
        e.tag = tag;
        q.push_back(e);
        for (int i = 0; i < 3; i++) begin
            if (!pwrok) begin
                m_code[i] = 7'(36 + 8 * int'({strap_clk, strap_dat}));
                m_psi[i]  = 1'b1;
            end else if (cmd_valid && int'(cmd_rail) == i) begin
                m_code[i] = cmd_byte[6:0];
                m_psi[i]  = cmd_byte[7];
            end
        end
        @(negedge clk);
    endtask

    task automatic send(int rail, logic [7:0] b, string tag);
        cmd_valid = 1'b1;
        cmd_rail  = 2'(rail);
        cmd_byte  = b;
        step({tag, " (R13 command cycle, old value)"});
        cmd_valid = 1'b0;
        step({tag, " (R13 value after store)"});
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (ser_out !== e.ser || par_out !== e.par || pvi_rb !== e.rb) begin
                errors++;
                $display("FAIL %s: ser=%h par=%0d rb=%h expected ser=%h par=%0d rb=%h",
                         e.tag, ser_out, par_out, pvi_rb, e.ser, e.par, e.rb);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual=hung expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (ser_out !== {3{8'hBC}} || par_out !== 5'd30 || pvi_rb !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: ser=%h par=%0d rb=%h expected ser=bcbcbc par=30 rb=00",
                     ser_out, par_out, pvi_rb);
        end
        rst = 1'b0;

        // R3 boot table per strap pair
        for (int s = 0; s < 4; s++) begin
            {strap_clk, strap_dat} = 2'(s);
            step("R3 boot strap");
        end
        // R2 fixed table, with and without pwrok
        vfix_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            {strap_clk, strap_dat} = 2'(s);
            step("R2 fixed strap");
        end
        pwrok = 1'b1;
        {strap_clk, strap_dat} = 2'b01;
        step("R2 fixed mode regardless of pwrok");
        vfix_en = 1'b0;
        step("R4 store keeps boot value after pwrok");

        // R4 serial commands with power-save flag
        send(1, 8'h20, "R4 core0 code 0x20 psi low");
        send(0, 8'h90, "R4 nb code 0x10 psi high");
        send(2, 8'h45, "R4 core1 code 0x45 psi low");

        // R5 trims and clamps
        off[1] = 8'd5;   step("R5 positive trim raises voltage");
        off[1] = 8'hF6;  step("R5 negative trim");
        off[0] = 8'h7F;  step("R5 clamp at top voltage");
        off[2] = 8'h80;  step("R5 clamp at 0x7B");
        off = '0;

        // R6 / R7 serial processor, parallel regulator
        out_serial = 1'b0;
        send(1, 8'h50, "R6 core0 clamped to 0x3D, par 30");
        send(1, 8'h3A, "R6 code inside limit");
        off[1] = 8'hFB;  step("R6 trim pushes past 0x3D");
        off = '0;
        send(1, 8'h21, "R7 odd code rounds to higher voltage");

        // R7 / R11 parallel processor, parallel regulator
        core_serial = 1'b0;
        pvi_in = 6'd5;   step("R7 parallel 5 to code 10");
        pvi_in = 6'd40;  step("R7 parallel 40 to code 71, par saturates");
        pvi_in = 6'd63;  step("R11 parallel 111111 reads 0x7E");
        mirror_sel = 2'b01; step("R10 mirror ignored in parallel output");
        mirror_sel = 2'b00;

        // R9 parallel processor, serial regulator
        out_serial = 1'b1;
        pvi_in = 6'd10;  step("R9 nb off code and psi high");
        mirror_sel = 2'b10; step("R10 off code overrides copy");
        mirror_sel = 2'b00;

        // R8 off code pass-through
        core_serial = 1'b1;
        off[2] = 8'd3;
        send(2, 8'hFE, "R8 off code untrimmed in serial output");
        out_serial = 1'b0; step("R8 off code trimmed in parallel output");
        out_serial = 1'b1;
        off = '0;

        // R10 mirroring
        mirror_sel = 2'b01; step("R10 core0 follows nb");
        mirror_sel = 2'b10; step("R10 nb follows core0");
        mirror_sel = 2'b00;

        // R12 manual override
        man_en[1] = 1'b1; man_code[1] = 7'h30;
        step("R12 manual code on core0");
        pwrok = 1'b0; step("R12 manual ignored before pwrok");
        pwrok = 1'b1; step("R12 manual again after pwrok");
        man_en = '0;
        send(0, 8'h11, "R4 command after pwrok returns");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule